// File: doc/BRIEF.md
# Dot-Matrix Display Scan Controller

This block refreshes a row of eight 5x7 dot-matrix characters by time-multiplexing their seven dot rows. Each row is given a fixed slot of display clocks. During a slot the block lights one row and drives the five column dots of every character for that row. Each character position holds an 8-bit code. The top bit of the code chooses between a built-in font pattern and one of sixteen user-defined patterns. The block reads both pattern stores through lookup ports. The font and user-pattern contents stay outside the block, so the font table can be replaced without touching the controller.

On top of the pattern data the block applies three kinds of gating. A 3-bit brightness code sets a duty step within each row slot. A per-character attribute makes a character flash. A whole-display blink blanks every character at once. Flash and blink share one slow timer that runs from reset, so all controllers reset together stay in step. To keep a single lookup port per store, the block fetches the next row's patterns during the current slot into a shadow buffer. It hands that buffer to the column outputs at the slot boundary.

Top module: `dotmatrix_scan_ctrl`

## Requirements
- R1: A row slot lasts 32 clocks and rows advance 0,1,...,6 then wrap to 0, so one full frame is 224 clocks. `row_sel` is one-hot with bit r lit during row r's slot. After n rising edges since reset release, the displayed row is (n mod 224)/32 and the slot phase is n mod 32.
- R2: A code with bit 7 = 0 requests font entry `code[6:0]` on `font_idx`. The five bits returned on `font_data` appear unchanged on that character's columns.
- R3: A code with bit 7 = 1 requests user pattern `code[3:0]` on `user_idx`. Bits 4..0 of `user_data` drive the columns, with bit 4 as the leftmost dot and bit 0 as the rightmost. Bits 7..5 of `user_data` have no effect.
- R4: The patterns shown during a row slot are fetched in the first 8 clocks of the preceding slot, one character per clock, for the row that follows. The first slot after reset shows all columns dark. A code change becomes visible from the second slot boundary after it at the latest.
- R5: The brightness code c selects N = 15,12,8,6,4,3,2,0 for c = 0..7. Columns are lit only while the slot phase is below 2*N, so phases 30 and 31 are always dark.
- R6: Brightness code 3'b111 forces every column to 0 at all times.
- R7: The flash/blink timer has a period of 28,672 clocks counted from reset release. Its first 14,336 clocks are the visible half and the rest are the dark half.
- R8: Character c (columns 5c+4..5c, attribute bit c) goes dark in the dark half only when `flash_en` = 1 and its `flash_attr` bit is 1. With `flash_en` = 0 the attribute bits have no effect.
- R9: With `blink_en` = 1, all eight characters go dark in the dark half whatever their attributes, which gives blink precedence over flash.
- R10: Row scanning continues unchanged while characters are dark for flash or blink.
- R11: Synchronous active-high reset returns the scan to row 0, phase 0, the timer to zero, and both pattern buffers to zero. The columns stay dark while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Display clock |
| rst | input | 1 | Synchronous active-high reset |
| char_codes | input | 64 | Code of character c in bits 8c+7..8c |
| flash_attr | input | 8 | Flash attribute bit per character |
| bright_code | input | 3 | Brightness step, 0 brightest, 7 blank |
| flash_en | input | 1 | Enables per-character flash |
| blink_en | input | 1 | Blinks the whole display, overrides flash |
| font_idx | output | 7 | Font entry being fetched |
| font_row | output | 3 | Row of the font entry being fetched |
| font_data | input | 5 | Font row dots, bit 4 leftmost |
| user_idx | output | 4 | User pattern being fetched |
| user_row | output | 3 | Row of the user pattern being fetched |
| user_data | input | 8 | User row dots in bits 4..0, bits 7..5 unused |
| row_sel | output | 7 | One-hot row select |
| col_data | output | 40 | Column dots, character c in bits 5c+4..5c, leftmost at 5c+4 |

## Verification
The row select, brightness, flash and blink gating are combinational from registered scan state. A result that follows n rising edges after reset release is therefore read at the falling edge after edge n, and the bench's model derives row, phase and timer half from that same n. Glyph data lags its fetch by one slot of 32 clocks, and the first slot after reset is dark. For that reason every sampled vector keeps its codes fixed from reset, and the mid-run code change is checked only after two slot boundaries have passed. The gating inputs are driven during reset and held, so they never change between a stimulus and its sample.

// File: rtl/dms_pkg.sv
package dms_pkg;

    // Glyph geometry fixed by the 5x7 font format
    localparam int ROWS      = 7;
    localparam int COLS      = 5;
    localparam int CODE_W    = 8;
    localparam int FONT_W    = 7;
    localparam int USER_W    = 4;
    localparam int BRIGHT_W  = 3;
    localparam int SUBSLOTS  = 15;
    localparam int ROW_W     = $clog2(ROWS);
    localparam int USER_DW   = 8;

    typedef enum logic {
        SRC_FONT = 1'b0,
        SRC_USER = 1'b1
    } glyph_src_e;

    typedef struct packed {
        glyph_src_e          src;
        logic [FONT_W-1:0]   font_idx;
        logic [USER_W-1:0]   user_idx;
    } glyph_ref_t;

    // Split a stored character code into its lookup request
    function automatic glyph_ref_t decode_code(input logic [CODE_W-1:0] code);
        glyph_ref_t r;
        r.src      = glyph_src_e'(code[CODE_W-1]);
        r.font_idx = code[FONT_W-1:0];
        r.user_idx = code[USER_W-1:0];
        return r;
    endfunction

    // Lit sub-slots per row slot for each brightness step
    function automatic logic [3:0] on_subslots(input logic [BRIGHT_W-1:0] code);
        logic [3:0] n;
        case (code)
            3'd0:    n = 4'd15;
            3'd1:    n = 4'd12;
            3'd2:    n = 4'd8;
            3'd3:    n = 4'd6;
            3'd4:    n = 4'd4;
            3'd5:    n = 4'd3;
            3'd6:    n = 4'd2;
            default: n = 4'd0;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/dms_scan_timer.sv
module dms_scan_timer #(
    parameter int SLOT_CLKS = 32,
    parameter int FLASH_DIV = 28672,
    localparam int PW = $clog2(SLOT_CLKS),
    localparam int FW = $clog2(FLASH_DIV),
    localparam int RW = dms_pkg::ROW_W
) (
    input  logic          clk,
    input  logic          rst,
    output logic [PW-1:0] phase_o,
    output logic [RW-1:0] row_o,
    output logic [RW-1:0] next_row_o,
    output logic          slot_end_o,
    output logic          dark_o
);
    import dms_pkg::*;

    logic [PW-1:0] phase_q;
    logic [RW-1:0] row_q;
    logic [FW-1:0] ftmr_q;
    logic          slot_end;
    logic [RW-1:0] row_nxt;

    assign slot_end = (phase_q == PW'(SLOT_CLKS - 1));
    assign row_nxt  = (row_q == RW'(ROWS - 1)) ? '0 : row_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            row_q   <= '0;
            ftmr_q  <= '0;
        end else begin
            phase_q <= slot_end ? '0 : phase_q + 1'b1;
            if (slot_end)
                row_q <= row_nxt;
            ftmr_q <= (ftmr_q == FW'(FLASH_DIV - 1)) ? '0 : ftmr_q + 1'b1;
        end
    end

    assign phase_o    = phase_q;
    assign row_o      = row_q;
    assign next_row_o = row_nxt;
    assign slot_end_o = slot_end;
    assign dark_o     = (ftmr_q >= FW'(FLASH_DIV / 2));

    // R1
    row_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!slot_end) |=> $stable(row_q));

    // R1
    row_step_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_end && row_q != RW'(ROWS - 1)) |=> (row_q == $past(row_q) + 1'b1));

    // R7
    dark_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dark_o) |-> (ftmr_q == FW'(FLASH_DIV / 2)));

endmodule

// File: rtl/dms_glyph_fetch.sv
module dms_glyph_fetch #(
    parameter int N_CHARS   = 8,
    parameter int SLOT_CLKS = 32,
    localparam int PW   = $clog2(SLOT_CLKS),
    localparam int CW   = (N_CHARS > 1) ? $clog2(N_CHARS) : 1,
    localparam int RW   = dms_pkg::ROW_W,
    localparam int PIXW = N_CHARS * dms_pkg::COLS
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic [N_CHARS*dms_pkg::CODE_W-1:0]     char_codes,
    input  logic [PW-1:0]                          phase_i,
    input  logic [RW-1:0]                          next_row_i,
    input  logic                                   slot_end_i,
    output logic [dms_pkg::FONT_W-1:0]             font_idx,
    output logic [RW-1:0]                          font_row,
    input  logic [dms_pkg::COLS-1:0]               font_data,
    output logic [dms_pkg::USER_W-1:0]             user_idx,
    output logic [RW-1:0]                          user_row,
    input  logic [dms_pkg::USER_DW-1:0]            user_data,
    output logic [PIXW-1:0]                        active_o
);
    import dms_pkg::*;

    logic                 fetch_act;
    logic [CW-1:0]        sel;
    logic [CODE_W-1:0]    code;
    glyph_ref_t           gref;
    logic [COLS-1:0]      pat;
    logic [COLS-1:0]      shadow_q [N_CHARS];
    logic [COLS-1:0]      active_q [N_CHARS];

    assign fetch_act = (int'(phase_i) < N_CHARS);
    assign sel       = CW'(phase_i);
    assign code      = char_codes[int'(sel)*CODE_W +: CODE_W];
    assign gref      = decode_code(code);

    assign font_idx  = gref.font_idx;
    assign font_row  = next_row_i;
    assign user_idx  = gref.user_idx;
    assign user_row  = next_row_i;

    always_comb begin
        if (gref.src == SRC_USER)
            pat = user_data[COLS-1:0];
        else
            pat = font_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int g = 0; g < N_CHARS; g++) begin
                shadow_q[g] <= '0;
                active_q[g] <= '0;
            end
        end else begin
            if (fetch_act)
                shadow_q[sel] <= pat;
            if (slot_end_i)
                for (int g = 0; g < N_CHARS; g++)
                    active_q[g] <= shadow_q[g];
        end
    end

    for (genvar g = 0; g < N_CHARS; g++) begin : g_out
        assign active_o[g*COLS +: COLS] = active_q[g];

        // R4
        swap_chk: assert property (@(posedge clk) disable iff (rst)
            slot_end_i |=> (active_q[g] == $past(shadow_q[g])));

        // R4
        hold_chk: assert property (@(posedge clk) disable iff (rst)
            (!slot_end_i) |=> $stable(active_q[g]));
    end

endmodule

// File: rtl/dms_pixel_gate.sv
module dms_pixel_gate #(
    parameter int N_CHARS   = 8,
    parameter int SLOT_CLKS = 32,
    parameter int SUB_CLKS  = 2,
    localparam int PW   = $clog2(SLOT_CLKS),
    localparam int RW   = dms_pkg::ROW_W,
    localparam int PIXW = N_CHARS * dms_pkg::COLS
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [PIXW-1:0]                active_i,
    input  logic [PW-1:0]                  phase_i,
    input  logic [RW-1:0]                  row_i,
    input  logic                           dark_i,
    input  logic [dms_pkg::BRIGHT_W-1:0]   bright_code,
    input  logic                           flash_en,
    input  logic                           blink_en,
    input  logic [N_CHARS-1:0]             flash_attr,
    output logic [dms_pkg::ROWS-1:0]       row_sel,
    output logic [PIXW-1:0]                col_data
);
    import dms_pkg::*;

    logic lit;

    always_comb begin
        lit = (int'(phase_i) < SUB_CLKS * int'(on_subslots(bright_code)));
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign row_sel[r] = (row_i == RW'(r));
    end

    for (genvar g = 0; g < N_CHARS; g++) begin : g_chr
        logic hide;
        assign hide = dark_i & (blink_en | (flash_en & flash_attr[g]));
        assign col_data[g*COLS +: COLS] = (lit && !hide) ? active_i[g*COLS +: COLS] : '0;
    end

    // R10
    row_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(row_sel) == 1);

    // R6
    blank_chk: assert property (@(posedge clk) disable iff (rst)
        (bright_code == 3'b111) |-> (col_data == '0));

    // R9
    blink_dark_chk: assert property (@(posedge clk) disable iff (rst)
        (blink_en && dark_i) |-> (col_data == '0));

    // R5
    guard_dark_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(phase_i) >= SUB_CLKS * SUBSLOTS) |-> (col_data == '0));

    // R8
    attr_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (!flash_en && !blink_en && bright_code == 3'b000 && int'(phase_i) < SUB_CLKS * SUBSLOTS)
        |-> (col_data == active_i));

endmodule

// File: rtl/dotmatrix_scan_ctrl.sv
module dotmatrix_scan_ctrl #(
    parameter int N_CHARS   = 8,
    parameter int SLOT_CLKS = 32,
    parameter int SUB_CLKS  = 2,
    parameter int FLASH_DIV = 28672,
    localparam int PW    = $clog2(SLOT_CLKS),
    localparam int RW    = dms_pkg::ROW_W,
    localparam int PIXW  = N_CHARS * dms_pkg::COLS,
    localparam int CODEW = N_CHARS * dms_pkg::CODE_W
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [CODEW-1:0]              char_codes,
    input  logic [N_CHARS-1:0]            flash_attr,
    input  logic [dms_pkg::BRIGHT_W-1:0]  bright_code,
    input  logic                          flash_en,
    input  logic                          blink_en,
    output logic [dms_pkg::FONT_W-1:0]    font_idx,
    output logic [RW-1:0]                 font_row,
    input  logic [dms_pkg::COLS-1:0]      font_data,
    output logic [dms_pkg::USER_W-1:0]    user_idx,
    output logic [RW-1:0]                 user_row,
    input  logic [dms_pkg::USER_DW-1:0]   user_data,
    output logic [dms_pkg::ROWS-1:0]      row_sel,
    output logic [PIXW-1:0]               col_data
);

    logic [PW-1:0]   phase;
    logic [RW-1:0]   row;
    logic [RW-1:0]   next_row;
    logic            slot_end;
    logic            dark;
    logic [PIXW-1:0] active;

    dms_scan_timer #(
        .SLOT_CLKS (SLOT_CLKS),
        .FLASH_DIV (FLASH_DIV)
    ) u_timer (
        .clk        (clk),
        .rst        (rst),
        .phase_o    (phase),
        .row_o      (row),
        .next_row_o (next_row),
        .slot_end_o (slot_end),
        .dark_o     (dark)
    );

    dms_glyph_fetch #(
        .N_CHARS   (N_CHARS),
        .SLOT_CLKS (SLOT_CLKS)
    ) u_fetch (
        .clk        (clk),
        .rst        (rst),
        .char_codes (char_codes),
        .phase_i    (phase),
        .next_row_i (next_row),
        .slot_end_i (slot_end),
        .font_idx   (font_idx),
        .font_row   (font_row),
        .font_data  (font_data),
        .user_idx   (user_idx),
        .user_row   (user_row),
        .user_data  (user_data),
        .active_o   (active)
    );

    dms_pixel_gate #(
        .N_CHARS   (N_CHARS),
        .SLOT_CLKS (SLOT_CLKS),
        .SUB_CLKS  (SUB_CLKS)
    ) u_gate (
        .clk         (clk),
        .rst         (rst),
        .active_i    (active),
        .phase_i     (phase),
        .row_i       (row),
        .dark_i      (dark),
        .bright_code (bright_code),
        .flash_en    (flash_en),
        .blink_en    (blink_en),
        .flash_attr  (flash_attr),
        .row_sel     (row_sel),
        .col_data    (col_data)
    );

    // R2
    font_row_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(row_sel << 1) == 0 |-> (font_row == '0));

endmodule

// File: tb/dotmatrix_scan_ctrl_tb.sv
module dotmatrix_scan_ctrl_tb;

    localparam int NV = 17;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] char_codes = '0;
    logic [7:0]  flash_attr = '0;
    logic [2:0]  bright_code = '0;
    logic        flash_en = 1'b0;
    logic        blink_en = 1'b0;
    logic [6:0]  font_idx;
    logic [2:0]  font_row;
    logic [4:0]  font_data;
    logic [3:0]  user_idx;
    logic [2:0]  user_row;
    logic [7:0]  user_data;
    logic [6:0]  row_sel;
    logic [39:0] col_data;
    logic [2:0]  junk = 3'b101;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    function automatic logic [4:0] font_fn(input logic [6:0] idx, input logic [2:0] row);
        return 5'((int'(idx) * 7) ^ (int'(row) * 11) ^ 3);
    endfunction

    function automatic logic [4:0] user_fn(input logic [3:0] idx, input logic [2:0] row);
        return 5'((int'(idx) * 13) ^ (int'(row) * 5) ^ 21);
    endfunction

    assign font_data = font_fn(font_idx, font_row);
    assign user_data = {junk, user_fn(user_idx, user_row)};

    dotmatrix_scan_ctrl u_dut (
        .clk         (clk),
        .rst         (rst),
        .char_codes  (char_codes),
        .flash_attr  (flash_attr),
        .bright_code (bright_code),
        .flash_en    (flash_en),
        .blink_en    (blink_en),
        .font_idx    (font_idx),
        .font_row    (font_row),
        .font_data   (font_data),
        .user_idx    (user_idx),
        .user_row    (user_row),
        .user_data   (user_data),
        .row_sel     (row_sel),
        .col_data    (col_data)
    );

    function automatic int on_steps(input logic [2:0] c);
        case (c)
            3'd0: return 15;
            3'd1: return 12;
            3'd2: return 8;
            3'd3: return 6;
            3'd4: return 4;
            3'd5: return 3;
            3'd6: return 2;
            default: return 0;
        endcase
    endfunction

    // Expected {row_sel, col_data} after n edges since reset release
    function automatic logic [46:0] model(input int n, input logic [63:0] codes,
                                          input logic [7:0] attr, input logic [2:0] br,
                                          input logic fen, input logic blk);
        int pos;
        int row;
        int ph;
        logic dark;
        logic lit;
        logic [39:0] cols;
        logic [6:0] rs;
        logic [7:0] code;
        logic [4:0] pat;
        logic hide;
        pos  = n % 224;
        row  = pos / 32;
        ph   = pos % 32;
        dark = ((n % 28672) >= 14336);
        lit  = (ph < 2 * on_steps(br));
        cols = '0;
        rs   = 7'(1) << row;
        if (n >= 32) begin
            for (int c = 0; c < 8; c++) begin
                code = codes[c*8 +: 8];
                pat  = code[7] ? user_fn(code[3:0], 3'(row)) : font_fn(code[6:0], 3'(row));
                hide = dark && (blk || (fen && attr[c]));
                if (lit && !hide)
                    cols[c*5 +: 5] = pat;
            end
        end
        return {rs, cols};
    endfunction

    localparam logic [63:0] CF = 64'h48_47_46_45_44_43_42_41;
    localparam logic [63:0] CU = 64'h8F_8E_8D_F5_83_82_81_80;
    localparam logic [63:0] CM = 64'h7E_9A_20_85_30_F3_5F_01;

    localparam logic [63:0] V_CODES [NV] = '{CF, CF, CU, CM, CM, CM, CM, CM, CM, CM,
                                             CM, CM, CM, CM, CM, CF, CM};
    localparam logic [7:0]  V_ATTR  [NV] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00,
                                             8'h00, 8'h5A, 8'hFF, 8'h0F, 8'h0F, 8'h5A, 8'h00,
                                             8'h00, 8'h00, 8'hFF};
    localparam logic [2:0]  V_BR    [NV] = '{3'd0, 3'd0, 3'd0, 3'd0, 3'd2, 3'd2, 3'd7, 3'd0,
                                             3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd6, 3'd6, 3'd0, 3'd0};
    localparam logic        V_FEN   [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 1, 1, 1, 0, 0, 0, 1};
    localparam logic        V_BLK   [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0, 0, 1};
    localparam int          V_N     [NV] = '{0, 40, 100, 677, 175, 176, 200, 62, 14376, 14376,
                                             14376, 14300, 28712, 67, 68, 20, 14436};

    function automatic string v_tag(input int i);
        case (i)
            0:  return "R11";
            1:  return "R2";
            2:  return "R3";
            3:  return "R1";
            4, 5, 7, 13, 14: return "R5";
            6:  return "R6";
            8, 9: return "R8";
            10: return "R9";
            11, 12: return "R7";
            15: return "R4";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string req, input logic [46:0] got, input logic [46:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: row_sel/col_data got %h expected %h", req, got, exp);
        end
    endtask

    task automatic start(input logic [63:0] codes, input logic [7:0] attr,
                         input logic [2:0] br, input logic fen, input logic blk);
        @(negedge clk);
        rst = 1'b1;
        char_codes = codes;
        flash_attr = attr;
        bright_code = br;
        flash_en = fen;
        blink_en = blk;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            start(V_CODES[i], V_ATTR[i], V_BR[i], V_FEN[i], V_BLK[i]);
            repeat (V_N[i]) @(negedge clk);
            check(v_tag(i), {row_sel, col_data},
                  model(V_N[i], V_CODES[i], V_ATTR[i], V_BR[i], V_FEN[i], V_BLK[i]));
        end

        // R3: upper user_data bits changed, columns must not move
        junk = 3'b010;
        start(CU, 8'h00, 3'd0, 1'b0, 1'b0);
        repeat (100) @(negedge clk);
        check("R3", {row_sel, col_data}, model(100, CU, 8'h00, 3'd0, 1'b0, 1'b0));
        junk = 3'b101;

        // R4: code change mid-run shows after two slot boundaries
        start(CF, 8'h00, 3'd0, 1'b0, 1'b0);
        repeat (300) @(negedge clk);
        char_codes = CM;
        repeat (70) @(negedge clk);
        check("R4", {row_sel, col_data}, model(370, CM, 8'h00, 3'd0, 1'b0, 1'b0));

        // R11: reset asserted mid-run returns to row 0 with dark columns
        repeat (50) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R11", {row_sel, col_data}, model(0, CM, 8'h00, 3'd0, 1'b0, 1'b0));
        rst = 1'b0;

        // R10: scanning continues through several dark-half rows
        start(CM, 8'hFF, 3'd0, 1'b1, 1'b1);
        repeat (14400) @(negedge clk);
        check("R10", {row_sel, col_data}, model(14400, CM, 8'hFF, 3'd0, 1'b1, 1'b1));
        repeat (64) @(negedge clk);
        check("R10", {row_sel, col_data}, model(14464, CM, 8'hFF, 3'd0, 1'b1, 1'b1));

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule